// File: doc/BRIEF.md
# Privilege-Checked Register File

This block holds the 32 architectural registers of a small 32-bit core. It also decides, for every write, whether the write is allowed. The status word is stored as register 11. Its two-bit current-level field (bits 12:11) sets the privilege used for that decision. Levels are encoded kernel = 0, executive = 1, supervisor = 2 and user = 3. Kernel may write every register. Any other level is refused on the status word (R11), the process-block pointer (R13), the interrupt stack pointer (R14) and the upper bank R24–R31. The upper bank can still be read from every level.

Two combinational read ports and one synchronous write port serve the datapath. A refused write leaves the register file untouched and raises a violation pulse, which the surrounding core may turn into an exception. A separate condition-code port lets the ALU load the N, Z, V and C bits of the status word from any level, without using a privileged write. The decoded current level is also brought out as an output.

Top module: `prf_regfile`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to zero, so every read returns 0 and `cur_level` reads 0 (kernel).
- R2: Each read port returns, in the same cycle, the stored value of the register its index selects; the two ports are independent.
- R3: `cur_level` equals status-word bits 12:11, encoded kernel=0, executive=1, supervisor=2, user=3.
- R4: At level 0 a write to any of the 32 indices is accepted, and `priv_viol` stays low.
- R5: At a level other than 0, a write to index 11, 13 or 14 is refused: the register keeps its value and `priv_viol` is high.
- R6: At a level other than 0, a write to index 24–31 is refused the same way, while reads of those indices stay available.
- R7: Indices 0–10, 12, 15 and 16–23 accept writes at every level.
- R8: `priv_viol` is high only in the cycle in which a refused write is presented (`wr_en` high); it is low in every other cycle.
- R9: Status-word bits 31:26 always read as zero; written values there are dropped.
- R10: A read of the register being written in the same cycle returns the old value; the new value appears from the next cycle.
- R11: When `cc_en` is high, status bits 21,20,19,18 are loaded from `cc_nzvc[3:0]` (N,Z,V,C) at any level. This holds even when a write to index 11 is refused in that cycle. When a permitted write to index 11 happens in the same cycle, the port's bits win over the written ones and the other status bits come from the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| cc_en | input | 1 | Condition-code load request |
| cc_nzvc | input | 4 | Condition codes N,Z,V,C (bit 3 = N) |
| cur_level | output | 2 | Current execution level from the status word |
| priv_viol | output | 1 | High during a refused write |

## Verification
The assertions assume that `wr_idx` and `wr_data` are stable and defined whenever `wr_en` is high. They also assume that `cc_nzvc` is defined whenever `cc_en` is high. Under those assumptions, the value a write leaves behind can be predicted from the previous cycle. The stimulus keeps every input known from the first clock after reset. It changes inputs only just after a rising edge, and it returns to the kernel level only through a kernel write or a reset, never by forcing state.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int XLEN     = 32;
  localparam int NREGS    = 32;
  localparam int RIDX_W   = $clog2(NREGS);

  typedef enum logic [1:0] {
    LVL_KERNEL = 2'd0,
    LVL_EXEC   = 2'd1,
    LVL_SUPV   = 2'd2,
    LVL_USER   = 2'd3
  } lvl_e;

  // register roles that change write permission
  localparam int SW_IDX   = 11;
  localparam int PCB_IDX  = 13;
  localparam int ISTK_IDX = 14;
  localparam int KBANK_LO = 24;

  // status word fields
  localparam int LVL_LO   = 11;
  localparam int LVL_HI   = 12;
  localparam int CC_LO    = 18;
  localparam int CC_W     = 4;
  localparam int USED_W   = 26;
endpackage

// File: rtl/prf_perm.sv
module prf_perm
  import prf_pkg::*;
#(
  parameter int N_REG  = NREGS,
  parameter int IDX_W  = RIDX_W
) (
  input  lvl_e             lvl,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             allow
);
  logic [N_REG-1:0] kernel_only;

  for (genvar g = 0; g < N_REG; g++) begin : g_mask
    if (g == SW_IDX || g == PCB_IDX || g == ISTK_IDX || g >= KBANK_LO) begin : g_k
      assign kernel_only[g] = 1'b1;
    end else begin : g_o
      assign kernel_only[g] = 1'b0;
    end
  end

  assign allow = (lvl == LVL_KERNEL) || !kernel_only[wr_idx];
endmodule

// File: rtl/prf_store.sv
module prf_store
  import prf_pkg::*;
#(
  parameter int W      = XLEN,
  parameter int N_REG  = NREGS,
  parameter int IDX_W  = RIDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             cc_en,
  input  logic [CC_W-1:0]  cc_nzvc,
  output logic [W-1:0]     regs_q [N_REG]
);
  localparam logic [W-1:0] SW_KEEP = {{(W-USED_W){1'b0}}, {USED_W{1'b1}}};

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    if (g == SW_IDX) begin : g_sw
      logic [W-1:0] sw_nxt;
      always_comb begin
        sw_nxt = regs_q[g];
        if (commit && wr_idx == IDX_W'(g)) sw_nxt = wr_data & SW_KEEP;
        if (cc_en) sw_nxt[CC_LO +: CC_W] = cc_nzvc;
      end
      always_ff @(posedge clk) begin
        if (rst) regs_q[g] <= '0;
        else     regs_q[g] <= sw_nxt;
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (rst)                                   regs_q[g] <= '0;
        else if (commit && wr_idx == IDX_W'(g))    regs_q[g] <= wr_data;
      end
    end
  end

  AST_SW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    regs_q[SW_IDX][W-1:USED_W] == '0); // R9

  AST_CC_LOADS: assert property (@(posedge clk) disable iff (rst)
    cc_en |=> regs_q[SW_IDX][CC_LO +: CC_W] == $past(cc_nzvc)); // R11

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (commit && !(cc_en && wr_idx == IDX_W'(SW_IDX))) |=>
      regs_q[$past(wr_idx)] == (($past(wr_idx) == IDX_W'(SW_IDX)) ?
                                ($past(wr_data) & SW_KEEP) : $past(wr_data))); // R4
endmodule

// File: rtl/prf_rdport.sv
module prf_rdport
  import prf_pkg::*;
#(
  parameter int W      = XLEN,
  parameter int N_REG  = NREGS,
  parameter int IDX_W  = RIDX_W
) (
  input  logic [W-1:0]     regs_q [N_REG],
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     data
);
  assign data = regs_q[idx];
endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
  import prf_pkg::*;
#(
  parameter int W      = XLEN,
  parameter int N_REG  = NREGS,
  localparam int IDX_W = $clog2(N_REG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [W-1:0]     rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [W-1:0]     rd_b_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             cc_en,
  input  logic [CC_W-1:0]  cc_nzvc,
  output logic [1:0]       cur_level,
  output logic             priv_viol
);
  logic [W-1:0] regs_q [N_REG];
  logic         allow;
  logic         commit;
  lvl_e         lvl;

  assign lvl       = lvl_e'(regs_q[SW_IDX][LVL_HI:LVL_LO]);
  assign cur_level = regs_q[SW_IDX][LVL_HI:LVL_LO];

  prf_perm #(.N_REG(N_REG), .IDX_W(IDX_W)) u_perm (
    .lvl    (lvl),
    .wr_idx (wr_idx),
    .allow  (allow)
  );

  assign commit    = wr_en && allow;
  assign priv_viol = wr_en && !allow;

  prf_store #(.W(W), .N_REG(N_REG), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cc_en   (cc_en),
    .cc_nzvc (cc_nzvc),
    .regs_q  (regs_q)
  );

  prf_rdport #(.W(W), .N_REG(N_REG), .IDX_W(IDX_W)) u_rd_a (
    .regs_q (regs_q),
    .idx    (rd_a_idx),
    .data   (rd_a_data)
  );

  prf_rdport #(.W(W), .N_REG(N_REG), .IDX_W(IDX_W)) u_rd_b (
    .regs_q (regs_q),
    .idx    (rd_b_idx),
    .data   (rd_b_data)
  );

  AST_RESET_KERNEL: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_level == 2'd0)); // R1

  AST_VIOL_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
    priv_viol |-> wr_en); // R8

  AST_KERNEL_NO_VIOL: assert property (@(posedge clk) disable iff (rst)
    (cur_level == 2'd0) |-> !priv_viol); // R4

  AST_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (priv_viol && !(cc_en && wr_idx == IDX_W'(SW_IDX))) |=>
      regs_q[$past(wr_idx)] == $past(regs_q[wr_idx])); // R5
endmodule

// File: tb/prf_regfile_tb.sv
module prf_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, cc_en = 1'b0;
  logic [3:0]  cc_nzvc = '0;
  logic [1:0]  cur_level;
  logic        priv_viol;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 rd_a, 1 rd_b, 2 viol, 3 level
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t exp_q[$];

  logic [31:0] model [32];

  always #4 clk = ~clk;

  prf_regfile u_dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cc_en(cc_en), .cc_nzvc(cc_nzvc),
    .cur_level(cur_level), .priv_viol(priv_viol)
  );

  function automatic bit kernel_only(int idx);
    return idx == 11 || idx == 13 || idx == 14 || idx >= 24;
  endfunction

  // monitor: compares everything the driver queued for this cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0:       act = rd_a_data;
        1:       act = rd_b_data;
        2:       act = {31'd0, priv_viol};
        default: act = {30'd0, cur_level};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; wr_en = 1'b0; cc_en = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  // driver: one cycle of stimulus plus expected results
  task automatic step(bit we, int wi, logic [31:0] wd, bit ce, logic [3:0] cc,
                      int ra, int rb, string req);
    logic [1:0] lvl;
    bit ok;
    item_t it;
    lvl = model[11][12:11];
    ok  = (lvl == 2'd0) || !kernel_only(wi);
    wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    cc_en = ce; cc_nzvc = cc;
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    it.req = req;
    it.kind = 0; it.exp = model[ra];                  exp_q.push_back(it);
    it.kind = 1; it.exp = model[rb];                  exp_q.push_back(it);
    it.kind = 2; it.exp = {31'd0, we && !ok};         exp_q.push_back(it);
    it.kind = 3; it.exp = {30'd0, lvl};               exp_q.push_back(it);
    @(posedge clk);
    if (we && ok) model[wi] = (wi == 11) ? (wd & 32'h03FF_FFFF) : wd;
    if (ce) model[11][21:18] = cc;
    #1;
  endtask

  initial begin
    int wlist[11] = '{11, 13, 14, 24, 31, 0, 9, 15, 16, 23, 12};
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    step(0, 0, 0, 0, 0, 5, 31, "R1");
    step(0, 0, 0, 0, 0, 11, 15, "R1");

    // R4 R10: kernel writes every index, read of same index sees old value
    for (int i = 0; i < 32; i++)
      step(1, i, (i == 11) ? 32'h0 : 32'h1000_0000 + i * 32'h0101, 0, 0, i, (i + 31) % 32, "R4 R10");
    // R2: independent read-back on both ports
    for (int i = 0; i < 32; i++)
      step(0, 0, 0, 0, 0, i, 31 - i, "R2");

    // R9: top status bits dropped (level field kept at kernel)
    step(1, 11, 32'hFFFF_E7FF, 0, 0, 11, 11, "R9");
    step(0, 0, 0, 0, 0, 11, 0, "R9");
    // R11: condition codes alone, then together with a status write
    step(0, 0, 0, 1, 4'b1010, 11, 11, "R11");
    step(1, 11, 32'h0000_0000, 1, 4'b0101, 11, 11, "R11");
    step(0, 0, 0, 0, 0, 11, 11, "R11");

    // R3 R5 R6 R7 R8 at each non-kernel level
    for (int l = 1; l < 4; l++) begin
      step(1, 11, 32'(l) << 11, 0, 0, 11, 0, "R3");
      step(0, 0, 0, 0, 0, 11, 0, "R3");
      foreach (wlist[k]) begin
        int idx = wlist[k];
        string tag = kernel_only(idx) ? ((idx >= 24) ? "R6" : "R5") : "R7";
        step(1, idx, 32'hA5A5_0000 + (l << 8) + idx, 0, 0, idx, 31, tag);
        step(0, 0, 0, 0, 0, idx, 24, "R8");
      end
      // R11: condition codes still load while a status write is refused
      step(1, 11, 32'h0, 1, 4'(l) ^ 4'b1001, 11, 11, "R11");
      step(0, 0, 0, 0, 0, 11, 11, "R11");
      do_reset();
      step(0, 0, 0, 0, 0, 11, 24, "R1");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule